// File: doc/BRIEF.md
# Converter Power-State Controller

This block decides, cycle by cycle, whether the core of a serial analog-to-digital converter is powered, whether its internal reference runs, and whether a conversion in flight must be abandoned. It watches a three-level shutdown pin, delivered to it already encoded as two bits, together with three strobes from the serial front end: a start bit was seen, a full control byte was accepted (carrying the power-keep bit and the clock-mode bit), and the current conversion finished.

Two kinds of power-down coexist. The pin acts at once: pulled low, it removes core and reference power and raises a one-cycle abort toward the conversion sequencer if a conversion is running. A control byte whose power-keep bit is clear is gentler: the conversion it launched runs to completion in the clock mode that byte chose, and only then does the core drop. A later start bit brings the core back. When the pin leaves the low level toward the floating level, which keeps the reference on, a wake-up counter loaded from `wake_len` must run out before `ready` asserts.

Top module: `adc_power_ctrl`

## Requirements
- R1: One cycle after `pin_state` is 2'b00 (low), `core_pwr_en`, `ref_en` and `ready` are all 0.
- R2: When `pin_state` goes to 2'b00 while a conversion is open (a control byte was accepted and no `conv_done` has followed), `conv_abort` is 1 for exactly the next cycle; with no open conversion it stays 0.
- R3: While `pin_state` is 2'b00, `start_det`, `ctrl_valid` and `conv_done` have no effect: the core stays off, `clk_mode_ext` keeps its value and no conversion is opened.
- R4: After a control byte with `ctrl_pd1` = 0, the core stays powered until `conv_done`, and `core_pwr_en` is 0 from the cycle after `conv_done`.
- R5: One cycle after `start_det` with the pin not low, `core_pwr_en` is 1.
- R6: After a control byte with `ctrl_pd1` = 1, `core_pwr_en` stays 1 after `conv_done`.
- R7: `ref_en` is 1 one cycle after the pin is floating and 0 after it is high or low; the core is powered for floating and high unless a software power-down is in effect.
- R8: In reset `core_pwr_en`, `ref_en`, `conv_abort` and `clk_mode_ext` are 0 (internal clock mode); one cycle after reset with the pin floating, core and reference are on.
- R9: `clk_mode_ext` takes `ctrl_pd0` (1 = external, 0 = internal) one cycle after each accepted control byte and keeps it through software power-down.
- R10: Leaving 2'b00 toward floating, `ready` stays 0 for exactly `wake_len` cycles after the first not-low cycle; leaving toward high, `ready` is 1 at once.
- R11: Pin code 2'b01 is floating, 2'b10 is high, and 2'b11 is treated exactly as floating.
- R12: When `start_det` and `conv_done` coincide after a byte with `ctrl_pd1` = 0, the start bit wins and the core stays powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_state | input | 2 | Encoded shutdown pin level: 00 low, 01 floating, 10 high, 11 floating |
| start_det | input | 1 | Start bit seen on the serial input (one-cycle strobe) |
| ctrl_valid | input | 1 | Control byte accepted, conversion begins (one-cycle strobe) |
| ctrl_pd1 | input | 1 | Power-keep bit of the accepted byte |
| ctrl_pd0 | input | 1 | Clock-mode bit of the accepted byte, 1 = external |
| conv_done | input | 1 | Conversion finished (one-cycle strobe) |
| wake_len | input | WAKE_W | Wake-up delay in cycles after leaving pin shutdown |
| core_pwr_en | output | 1 | Converter core powered |
| ref_en | output | 1 | Internal reference enabled |
| conv_abort | output | 1 | One-cycle request to stop the running conversion |
| clk_mode_ext | output | 1 | Selected conversion clock mode, 1 = external |
| ready | output | 1 | Core powered and wake-up delay elapsed |

## Verification
The sharpest collisions are a pin drop landing in the same cycle as an open conversion, which must both cut power and raise the abort, and a `start_det` landing together with the `conv_done` that would otherwise complete a deferred power-down. The bench drives both pairs on the same clock edge and judges the outcome only at the ports one cycle later: abort high for one cycle and power off in the first case, power still on in the second. A sweep over wake lengths and release levels then counts the cycles until `ready` and compares them with the arithmetic expectation.

// File: rtl/adc_power_pkg.sv
package adc_power_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_OPEN = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_ALT  = 2'b11
  } pin_lvl_e;

  function automatic logic lvl_is_low(input logic [1:0] lvl);
    return lvl == LVL_LOW;
  endfunction

  function automatic logic lvl_is_open(input logic [1:0] lvl);
    return (lvl == LVL_OPEN) || (lvl == LVL_ALT);
  endfunction
endpackage

// File: rtl/adc_pin_stage.sv
module adc_pin_stage
  import adc_power_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pin_state,
  output logic       low_now,
  output logic       open_now,
  output logic       low_q,
  output logic       open_q
);
  assign low_now  = lvl_is_low(pin_state);
  assign open_now = lvl_is_open(pin_state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= 1'b1;
      open_q <= 1'b0;
    end else begin
      low_q  <= low_now;
      open_q <= open_now;
    end
  end
endmodule

// File: rtl/adc_soft_pd.sv
module adc_soft_pd (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_low,
  input  logic start_det,
  input  logic ctrl_valid,
  input  logic ctrl_pd1,
  input  logic ctrl_pd0,
  input  logic conv_done,
  output logic soft_off,
  output logic clk_ext,
  output logic abort
);
  logic busy;
  logic pend_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pend_off <= 1'b0;
      soft_off <= 1'b0;
      clk_ext  <= 1'b0;
      abort    <= 1'b0;
    end else if (hw_low) begin
      abort    <= busy;
      busy     <= 1'b0;
      pend_off <= 1'b0;
      soft_off <= 1'b0;
    end else begin
      abort <= 1'b0;
      if (ctrl_valid) begin
        busy     <= 1'b1;
        pend_off <= ~ctrl_pd1;
        clk_ext  <= ctrl_pd0;
      end else if (conv_done) begin
        busy <= 1'b0;
      end
      if (start_det) begin
        soft_off <= 1'b0;
      end else if (conv_done && pend_off) begin
        soft_off <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_wake_timer.sv
module adc_wake_timer #(
  parameter int WAKE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              low_now,
  input  logic              open_now,
  input  logic              low_q,
  input  logic [WAKE_W-1:0] wake_len,
  output logic              settled
);
  localparam logic [WAKE_W-1:0] ZERO = '0;
  localparam logic [WAKE_W-1:0] ONE  = {{(WAKE_W-1){1'b0}}, 1'b1};

  logic [WAKE_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= ZERO;
    end else if (low_now || !open_now) begin
      remain <= ZERO;
    end else if (low_q) begin
      remain <= wake_len;
    end else if (remain != ZERO) begin
      remain <= remain - ONE;
    end
  end

  assign settled = (remain == ZERO);
endmodule

// File: rtl/adc_power_ctrl.sv
module adc_power_ctrl #(
  parameter int WAKE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pin_state,
  input  logic              start_det,
  input  logic              ctrl_valid,
  input  logic              ctrl_pd1,
  input  logic              ctrl_pd0,
  input  logic              conv_done,
  input  logic [WAKE_W-1:0] wake_len,
  output logic              core_pwr_en,
  output logic              ref_en,
  output logic              conv_abort,
  output logic              clk_mode_ext,
  output logic              ready
);
  logic low_now, open_now, low_q, open_q;
  logic soft_off, settled;

  adc_pin_stage u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_state(pin_state),
    .low_now  (low_now),
    .open_now (open_now),
    .low_q    (low_q),
    .open_q   (open_q)
  );

  adc_soft_pd u_soft (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_low    (low_now),
    .start_det (start_det),
    .ctrl_valid(ctrl_valid),
    .ctrl_pd1  (ctrl_pd1),
    .ctrl_pd0  (ctrl_pd0),
    .conv_done (conv_done),
    .soft_off  (soft_off),
    .clk_ext   (clk_mode_ext),
    .abort     (conv_abort)
  );

  adc_wake_timer #(.WAKE_W(WAKE_W)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .low_now (low_now),
    .open_now(open_now),
    .low_q   (low_q),
    .wake_len(wake_len),
    .settled (settled)
  );

  assign core_pwr_en = ~low_q & ~soft_off;
  assign ref_en      = open_q;
  assign ready       = core_pwr_en & settled;
endmodule

// File: rtl/adc_power_ctrl_chk.sv
module adc_power_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pin_state,
  input logic       start_det,
  input logic       ctrl_valid,
  input logic       ctrl_pd0,
  input logic       core_pwr_en,
  input logic       ref_en,
  input logic       conv_abort,
  input logic       clk_mode_ext,
  input logic       ready
);
  p_pin_low_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_state == 2'b00) |=> (!core_pwr_en && !ref_en && !ready));

  p_abort_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |=> !conv_abort);

  p_abort_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> ($past(pin_state) == 2'b00));

  p_start_wakes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && pin_state != 2'b00) |=> core_pwr_en);

  p_ref_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_state[0] |=> ref_en);

  p_ref_shut_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_state[0] |=> !ref_en);

  p_clk_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_valid && pin_state != 2'b00) |=> (clk_mode_ext == $past(ctrl_pd0)));
endmodule

bind adc_power_ctrl adc_power_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_state   (pin_state),
  .start_det   (start_det),
  .ctrl_valid  (ctrl_valid),
  .ctrl_pd0    (ctrl_pd0),
  .core_pwr_en (core_pwr_en),
  .ref_en      (ref_en),
  .conv_abort  (conv_abort),
  .clk_mode_ext(clk_mode_ext),
  .ready       (ready)
);

// File: tb/test_adc_power_ctrl.sv
module test_adc_power_ctrl;
  localparam int WAKE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pin_state = 2'b01;
  logic start_det = 1'b0, ctrl_valid = 1'b0, ctrl_pd1 = 1'b0, ctrl_pd0 = 1'b0, conv_done = 1'b0;
  logic [WAKE_W-1:0] wake_len = '0;
  logic core_pwr_en, ref_en, conv_abort, clk_mode_ext, ready;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  adc_power_ctrl #(.WAKE_W(WAKE_W)) i_adc_power_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_state(pin_state), .start_det(start_det),
    .ctrl_valid(ctrl_valid), .ctrl_pd1(ctrl_pd1), .ctrl_pd0(ctrl_pd0),
    .conv_done(conv_done), .wake_len(wake_len), .core_pwr_en(core_pwr_en),
    .ref_en(ref_en), .conv_abort(conv_abort), .clk_mode_ext(clk_mode_ext),
    .ready(ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: inputs held, outputs sampled at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    start_det = 1'b0; ctrl_valid = 1'b0; conv_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R8 core in reset", core_pwr_en, 0);
    chk("R8 ref in reset", ref_en, 0);
    chk("R8 abort in reset", conv_abort, 0);
    chk("R8 clock mode in reset", clk_mode_ext, 0);
    rst_n = 1'b1;
    step();
    chk("R8 core after reset", core_pwr_en, 1);
    chk("R8 ref after reset", ref_en, 1);
    chk("R10 ready with zero wake", ready, 1);

    // R7 / R11: every pin code
    for (int p = 3; p >= 0; p--) begin
      pin_state = 2'(p);
      step();
      chk($sformatf("R7 R11 ref for code %0d", p), ref_en, p % 2);
      chk($sformatf("R7 core for code %0d", p), core_pwr_en, (p != 0) ? 1 : 0);
    end
    pin_state = 2'b01; step();

    // R5 / R4 / R9: deferred power-down in external mode
    start_det = 1'b1; step();
    chk("R5 core on after start", core_pwr_en, 1);
    ctrl_valid = 1'b1; ctrl_pd1 = 1'b0; ctrl_pd0 = 1'b1; step();
    chk("R9 external mode latched", clk_mode_ext, 1);
    step(); step();
    chk("R4 core held during conversion", core_pwr_en, 1);
    conv_done = 1'b1; step();
    chk("R4 core off after done", core_pwr_en, 0);
    chk("R9 mode kept in power-down", clk_mode_ext, 1);
    step();
    chk("R4 core remains off", core_pwr_en, 0);

    // R5 / R6: keep-powered byte
    start_det = 1'b1; step();
    chk("R5 start wakes from soft power-down", core_pwr_en, 1);
    ctrl_valid = 1'b1; ctrl_pd1 = 1'b1; ctrl_pd0 = 1'b0; step();
    chk("R9 internal mode latched", clk_mode_ext, 0);
    conv_done = 1'b1; step();
    chk("R6 core stays on after done", core_pwr_en, 1);

    // R12: start and done together
    ctrl_valid = 1'b1; ctrl_pd1 = 1'b0; step();
    conv_done = 1'b1; start_det = 1'b1; step();
    chk("R12 start beats deferred power-down", core_pwr_en, 1);
    ctrl_valid = 1'b1; ctrl_pd1 = 1'b1; step();
    conv_done = 1'b1; step();

    // R1 / R2: pin drop during conversion
    ctrl_valid = 1'b1; ctrl_pd1 = 1'b1; step();
    pin_state = 2'b00; step();
    chk("R2 abort on drop while busy", conv_abort, 1);
    chk("R1 core off", core_pwr_en, 0);
    chk("R1 ref off", ref_en, 0);
    chk("R1 ready off", ready, 0);
    step();
    chk("R2 abort lasts one cycle", conv_abort, 0);
    pin_state = 2'b10; step();
    pin_state = 2'b00; step();
    chk("R2 no abort when idle", conv_abort, 0);

    // R3: strobes ignored while low
    start_det = 1'b1; step();
    chk("R3 start ignored", core_pwr_en, 0);
    ctrl_valid = 1'b1; ctrl_pd0 = 1'b1; step();
    chk("R3 mode untouched", clk_mode_ext, 0);
    pin_state = 2'b10; step();
    chk("R3 core back on pin high", core_pwr_en, 1);
    pin_state = 2'b00; step();
    chk("R3 no conversion was opened", conv_abort, 0);

    // R10 sweep: wake lengths by release level
    for (int w = 0; w <= 6; w++) begin
      for (int t = 1; t <= 3; t++) begin
        int n;
        pin_state = 2'b00; step();
        wake_len = WAKE_W'(w);
        pin_state = 2'(t); step();
        n = 0;
        while (!ready && n < 50) begin
          step();
          n++;
        end
        chk($sformatf("R10 wake cycles w=%0d code=%0d", w, t), n, (t % 2 == 1) ? w : 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule